// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a high-rate clock by a programmable integer for the feedback path of a frequency synthesizer. A fixed divide-by-4 stage feeds a dual-modulus prescaler. The prescaler runs at either 8/9 or 16/17. A swallow counter (A, 6 bits) and a main counter (B, 13 bits) advance only once per prescaler cycle. For the first A prescaler cycles of each output period the prescaler divides by P+1. For the remaining B−A cycles it divides by P. The total division from the clock input is therefore 4·(B·P + A). The two programmable counters never run at the input rate.

A small state machine steers the prescaler. Its states are `ST_IDLE` (no legal setting loaded yet, all counters parked), `ST_SWALLOW` (swallow count non-zero, modulus P+1) and `ST_MAIN` (swallow count exhausted, modulus P).

Its transitions are:
- IDLE→SWALLOW or IDLE→MAIN when a legal setting is first presented.
- SWALLOW→SWALLOW on each prescaler cycle while swallow cycles remain.
- SWALLOW→MAIN when the last swallow cycle ends.
- MAIN→MAIN on each prescaler cycle while main cycles remain.
- The end of the output period (main count expiring), from SWALLOW or MAIN, goes to SWALLOW or MAIN depending on the swallow count being loaded.

A setting is legal when B ≥ A and B ≥ 3. An illegal setting raises the error flag, and the divider keeps running on the last legal setting. The inputs are sampled only at the end of an output period.

Top module: `psd_divider`

## Requirements
- R1: With mod_sel=0 selecting P=8 (8/9) and mod_sel=1 selecting P=16 (16/17), consecutive rising pulses on div_out are exactly 4·(B·P+A) clock cycles apart, where B=main_cnt and A=swallow_cnt.
- R2: div_out is high for exactly one clock cycle per output period.
- R3: With P=16 and B=3, A values 0, 1, 2 and 3 give periods of 192, 196, 200 and 204 clock cycles.
- R4: A setting with B < A (for example P=16, B=3, A=14) sets cfg_err high from the first clock edge after it appears. The divider keeps producing the period of the last legal setting.
- R5: A setting with B < 3 is treated as illegal in the same way as R4.
- R6: Inputs are taken only on the clock edge that raises div_out. The period that is running keeps its setting even if the inputs change in the middle of it. The period that starts at the next pulse uses the inputs present one cycle before that pulse.
- R7: During reset, div_out and cfg_err are 0. After reset, no pulse appears until a legal setting is presented, and cfg_err reports an illegal setting even in that state.
- R8: Within each output period the prescaler runs at P+1 for exactly A prescaler cycles and at P for the rest. This covers A=0 (never P+1) and A=B (always P+1).
- R9: cfg_err returns to 0 from the first clock edge after a legal setting is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_sel | input | 1 | Prescaler pair select: 0 = 8/9, 1 = 16/17 |
| swallow_cnt | input | 6 | Swallow count A |
| main_cnt | input | 13 | Main count B |
| div_out | output | 1 | One-cycle pulse per output period |
| cfg_err | output | 1 | High while the presented setting is illegal |

## Verification
Two results have different timing.

- **cfg_err** is registered, so it reflects a new setting one clock edge after it is driven. The bench drives each setting on a falling edge and reads the flag on the next falling edge.
- **Pulse period** depends on a setting that is taken only at a period boundary. The bench changes the inputs just after a pulse. The period it queues for that setting is compared against the gap between the next pulse and the one after it, counted in falling edges.

The period still in flight when the inputs change is compared against the previous setting. This is how R6 is checked. For an illegal setting, the bench queues the period of the last legal setting.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Control states of the swallow/main sequencer.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } psd_state_e;

    // Fixed front-stage ratio and the smallest main count allowed.
    localparam int PSD_PREDIV = 4;
    localparam int PSD_MIN_B  = 3;

endpackage

// File: rtl/psd_prediv.sv
// Fixed front divider: one enable tick every DIV input cycles while run is high.
module psd_prediv #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic q_tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_bypass
            assign q_tick = run;
        end else begin : g_count
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || !run) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end

            assign q_tick = run && (cnt == CW'(DIV - 1));

            // R1
            qtick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                q_tick |=> !q_tick);
        end
    endgenerate

endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus stage: counts front-stage ticks, divides by P or P+1.
module psd_prescaler #(
    parameter int P_LO = 8,
    parameter int P_HI = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic in_tick,
    input  logic sel_hi,
    input  logic plus_one,
    output logic out_tick
);

    localparam int CW = $clog2(P_HI + 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] base;
    logic [CW-1:0] last;

    assign base = sel_hi ? CW'(P_HI) : CW'(P_LO);
    assign last = base + CW'(plus_one) - CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (in_tick) begin
            if (cnt == last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign out_tick = in_tick && (cnt == last);

    // R1
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= last));

endmodule

// File: rtl/psd_ctrl.sv
// Swallow/main sequencer: holds the active setting, counts prescaler cycles,
// selects the prescaler modulus and emits the output pulse.
module psd_ctrl
    import psd_pkg::*;
#(
    parameter int A_W   = 6,
    parameter int B_W   = 13,
    parameter int MIN_B = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           p_tick,
    input  logic           req_hi,
    input  logic [A_W-1:0] req_a,
    input  logic [B_W-1:0] req_b,
    output logic           run,
    output logic           plus_one,
    output logic           sel_hi,
    output logic           pulse,
    output logic           err
);

    psd_state_e     state, nxt;
    logic [A_W-1:0] a_cnt;
    logic [B_W-1:0] b_cnt;
    logic [A_W-1:0] cfg_a;
    logic [B_W-1:0] cfg_b;
    logic           cfg_hi;
    logic           req_ok;
    logic           term;
    logic           load;
    logic [A_W-1:0] src_a;
    logic [B_W-1:0] src_b;
    logic           src_hi;

    // Legality of the presented setting.
    assign req_ok = (req_b >= B_W'(req_a)) && (req_b >= B_W'(MIN_B));

    // End of the output period: last main cycle completes.
    assign term = (state != ST_IDLE) && p_tick && (b_cnt == B_W'(1));
    assign load = term || ((state == ST_IDLE) && req_ok);

    // Setting used for the next period.
    assign src_a  = req_ok ? req_a  : cfg_a;
    assign src_b  = req_ok ? req_b  : cfg_b;
    assign src_hi = req_ok ? req_hi : cfg_hi;

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_ok) begin
                    nxt = (req_a != '0) ? ST_SWALLOW : ST_MAIN;
                end
            end
            ST_SWALLOW: begin
                if (term) begin
                    nxt = (src_a != '0) ? ST_SWALLOW : ST_MAIN;
                end else if (p_tick && (a_cnt == A_W'(1))) begin
                    nxt = ST_MAIN;
                end
            end
            ST_MAIN: begin
                if (term) begin
                    nxt = (src_a != '0) ? ST_SWALLOW : ST_MAIN;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Counters, held setting and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cnt  <= '0;
            b_cnt  <= '0;
            cfg_a  <= '0;
            cfg_b  <= B_W'(MIN_B);
            cfg_hi <= 1'b0;
            pulse  <= 1'b0;
            err    <= 1'b0;
        end else begin
            err   <= !req_ok;
            pulse <= term;
            if (load) begin
                a_cnt <= src_a;
                b_cnt <= src_b;
                if (req_ok) begin
                    cfg_a  <= req_a;
                    cfg_b  <= req_b;
                    cfg_hi <= req_hi;
                end
            end else if (p_tick && (state != ST_IDLE)) begin
                b_cnt <= b_cnt - B_W'(1);
                if (a_cnt != '0) begin
                    a_cnt <= a_cnt - A_W'(1);
                end
            end
        end
    end

    assign run      = (state != ST_IDLE);
    assign plus_one = (state == ST_SWALLOW);
    assign sel_hi   = cfg_hi;

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R4
    ab_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (B_W'(a_cnt) <= b_cnt));

    // R5
    min_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cfg_b >= B_W'(MIN_B)));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !term) |=> $stable({cfg_hi, cfg_a, cfg_b}));

    // R8
    swallow_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWALLOW) |-> (a_cnt != '0));

    // R8
    main_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MAIN) |-> (a_cnt == '0));

endmodule

// File: rtl/psd_divider.sv
// Top: fixed front divider, dual-modulus prescaler and swallow/main sequencer.
module psd_divider
    import psd_pkg::*;
#(
    parameter int A_W  = 6,
    parameter int B_W  = 13,
    parameter int P_LO = 8,
    parameter int P_HI = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mod_sel,
    input  logic [A_W-1:0] swallow_cnt,
    input  logic [B_W-1:0] main_cnt,
    output logic           div_out,
    output logic           cfg_err
);

    logic run;
    logic q_tick;
    logic p_tick;
    logic plus_one;
    logic sel_hi;

    psd_prediv #(
        .DIV (PSD_PREDIV)
    ) u_prediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .q_tick (q_tick)
    );

    psd_prescaler #(
        .P_LO (P_LO),
        .P_HI (P_HI)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .in_tick  (q_tick),
        .sel_hi   (sel_hi),
        .plus_one (plus_one),
        .out_tick (p_tick)
    );

    psd_ctrl #(
        .A_W   (A_W),
        .B_W   (B_W),
        .MIN_B (PSD_MIN_B)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .p_tick   (p_tick),
        .req_hi   (mod_sel),
        .req_a    (swallow_cnt),
        .req_b    (main_cnt),
        .run      (run),
        .plus_one (plus_one),
        .sel_hi   (sel_hi),
        .pulse    (div_out),
        .err      (cfg_err)
    );

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !div_out);

endmodule

// File: tb/psd_divider_tb.sv
module psd_divider_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_sel = 1'b1;
    logic [5:0]  swallow_cnt = 6'd14;
    logic [12:0] main_cnt = 13'd3;
    logic        div_out;
    logic        cfg_err;

    int checks = 0;
    int fails = 0;
    int exp_q[$];
    string tag_q[$];
    int cyc = 0;
    int last_pulse = -1;
    int pulse_count = 0;
    int last_legal = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psd_divider u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mod_sel     (mod_sel),
        .swallow_cnt (swallow_cnt),
        .main_cnt    (main_cnt),
        .div_out     (div_out),
        .cfg_err     (cfg_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int period_of(input bit hi, input int b, input int a);
        return 4 * (b * (hi ? 16 : 8) + a);
    endfunction

    // Monitor: measures gaps between pulses and compares them against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (div_out) begin
                pulse_count++;
                if (last_pulse >= 0 && exp_q.size() > 0) begin
                    int e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check((cyc - last_pulse) == e, t, cyc - last_pulse, e);
                end
                last_pulse = cyc;
            end
        end
    end

    task automatic wait_pulse();
        do @(negedge clk); while (!div_out);
    endtask

    // Driver: applies a setting right after a pulse and queues its period.
    task automatic apply(input bit hi, input int b, input int a, input string tag);
        bit legal;
        legal = (b >= a) && (b >= 3);
        wait_pulse();
        mod_sel = hi;
        main_cnt = 13'(b);
        swallow_cnt = 6'(a);
        if (legal) begin
            last_legal = period_of(hi, b, a);
        end
        exp_q.push_back(last_legal);
        tag_q.push_back(tag);
        @(negedge clk);
        if (legal) begin
            // R9
            check(cfg_err == 1'b0, "R9", int'(cfg_err), 0);
        end else begin
            // R4 / R5
            check(cfg_err == 1'b1, (b < 3) ? "R5" : "R4", int'(cfg_err), 1);
        end
    endtask

    initial begin
        // R7: reset state.
        repeat (3) @(negedge clk);
        check(div_out == 1'b0, "R7", int'(div_out), 0);
        check(cfg_err == 1'b0, "R7", int'(cfg_err), 0);
        rst_n = 1'b1;

        // R7 / R4: illegal setting (P=16, B=3, A=14) after reset keeps the block idle.
        repeat (2) @(negedge clk);
        check(cfg_err == 1'b1, "R4", int'(cfg_err), 1);
        repeat (300) @(negedge clk);
        check(pulse_count == 0, "R7", pulse_count, 0);

        // First legal setting: P=16, B=3, A=0.
        swallow_cnt = 6'd0;
        last_legal = period_of(1'b1, 3, 0);
        exp_q.push_back(last_legal);
        tag_q.push_back("R3");
        @(negedge clk);
        check(cfg_err == 1'b0, "R9", int'(cfg_err), 0);

        // R3: moduli 49, 50, 51 with B=3, then 52 (A=4) is illegal.
        apply(1'b1, 3, 1, "R3");
        apply(1'b1, 3, 2, "R3");
        apply(1'b1, 3, 3, "R3_r8_all_swallow");
        apply(1'b1, 3, 4, "R4_hold");
        // R8: all-main and all-swallow on 8/9.
        apply(1'b0, 3, 0, "R8_no_swallow");
        apply(1'b0, 5, 5, "R8_all_swallow");
        apply(1'b1, 2, 0, "R5_hold");
        apply(1'b1, 3, 14, "R4_hold");
        apply(1'b0, 10, 0, "R1");
        apply(1'b1, 40, 39, "R1");

        // R1 / R6: random legal settings; each change lands mid-period.
        for (int i = 0; i < 20; i++) begin
            int b;
            int a;
            b = int'($urandom_range(3, 30));
            a = int'($urandom_range(0, b));
            apply(1'($urandom_range(0, 1)), b, a, (i % 2) ? "R1" : "R6");
        end

        // Drain the queue.
        for (int k = 0; k < 4 && exp_q.size() > 0; k++) begin
            wait_pulse();
        end
        // R2: pulse is one cycle wide.
        wait_pulse();
        @(negedge clk);
        check(div_out == 1'b0, "R2", int'(div_out), 0);
        check(exp_q.size() == 0, "R1", exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule